// File: doc/BRIEF.md
# Legacy System I/O Register Block

This block sits on a byte-wide I/O-port bus of a workstation system board and answers a small set of 16-bit port addresses. It holds three control registers: a soft-reset register, a system-control register and an I/O-map-mode register. The first and the last drive dedicated output lines. It also returns two board straps, for equipment and board identity, which are fixed by parameters at build time. A few ports only take writes and discard them. One port only gives reads and always reads zero.

Control bits use reversed numbering: logical bit n of a byte is mask `8'h80 >> n`, so logical bit 0 is the MSB and logical bit 7 is the LSB. A separate 32-bit memory-mapped read port returns a parity-error status word that is always zero. A write to the soft-reset port that asks for little-endian operation raises a one-cycle error pulse, because that mode is not supported.

The bus reset `rst_n` asserts asynchronously. Its release is synchronised inside the block. Read data appear one cycle after the read strobe.

Top module: `sysio_regblk`

## Requirements
- R1: While reset is active and directly after it, `soft_rst_o`=0, `map_noncontig_o`=1, `le_mode_err_o`=0, `io_rdata`=0x00 and `mem_ack`=0. The system-control register holds 0x00.
- R2: Port 0x0092 stores only mask 0x01 (logical bit 7) of a written byte. `soft_rst_o` shows the stored bit from the cycle after the write. A read of 0x0092 returns only that bit.
- R3: A write to 0x0092 with mask 0x02 (logical bit 6) set makes `le_mode_err_o` high for exactly the next cycle. That bit is never stored or read back.
- R4: A write to port 0x081C keeps only mask 0xF0 (logical bits 0 to 3), and the rest of the byte is discarded. A read returns the kept value.
- R5: Port 0x0850 stores only mask 0x01. The stored bit drives `map_noncontig_o` from the cycle after the write, and a read returns it.
- R6: Ports 0x080C and 0x0852 read `EQUIP_STRAP` and `BOARD_ID` respectively. Writes to them change nothing.
- R7: Port 0x0818 always reads 0x00, and writes to it change nothing.
- R8: Writes to ports 0x0808, 0x0810, 0x0812 and 0x0814 are accepted and change no register or output. Reads of them return 0x00.
- R9: Reads of any undecoded port address return 0x00. Writes to one change nothing.
- R10: `io_rdata` carries the read value in the cycle after `io_rd` and is 0x00 in every other cycle. If a read and a write arrive together, the read returns the value held before that write.
- R11: A read with `mem_be`=4'b1111 at `mem_addr`=`PARITY_ADDR` gives `mem_ack`=1 in the next cycle with `mem_rdata`=0. Any other address or byte-enable pattern gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | IO_AW | I/O port address |
| io_wdata | input | 8 | I/O write byte |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read byte, one cycle after `io_rd` |
| mem_addr | input | MEM_AW | Memory read address |
| mem_be | input | 4 | Memory byte enables |
| mem_rd | input | 1 | Memory read strobe |
| mem_rdata | output | 32 | Parity status word |
| mem_ack | output | 1 | Memory read accepted, one cycle after the strobe |
| soft_rst_o | output | 1 | Soft-reset line |
| map_noncontig_o | output | 1 | Non-contiguous I/O map mode line |
| le_mode_err_o | output | 1 | One-cycle pulse on a request for the unsupported mode |

## Verification
The bench builds the block with `EQUIP_STRAP`=0xA5 and `BOARD_ID`=0x3C. With these values both strap ports read something other than zero, so a swap of the two, a strap that drifts to zero, or a strap that leaks onto the read-zero ports would all show up. The default parity address and a two-stage reset synchroniser are kept, so the mid-run reset exercises the asynchronous assert and the delayed release. Random traffic mixes every decoded port with neighbouring addresses, with simultaneous reads and writes, and with partial-width memory reads.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  localparam int unsigned IO_DW = 8;

  // Reversed numbering: logical bit n sits at mask 0x80 >> n.
  function automatic logic [IO_DW-1:0] lbit(input int unsigned n);
    return 8'h80 >> n;
  endfunction

  localparam logic [15:0] P_SRESET = 16'h0092;
  localparam logic [15:0] P_EQUIP  = 16'h080C;
  localparam logic [15:0] P_KEY    = 16'h0818;
  localparam logic [15:0] P_SYSCTL = 16'h081C;
  localparam logic [15:0] P_IOMAP  = 16'h0850;
  localparam logic [15:0] P_BOARD  = 16'h0852;

  localparam int unsigned N_SINK = 4;
  localparam logic [N_SINK-1:0][15:0] P_SINKS =
    {16'h0814, 16'h0812, 16'h0810, 16'h0808};

  localparam logic [IO_DW-1:0] SRESET_KEEP = lbit(7);
  localparam logic [IO_DW-1:0] LE_REQ      = lbit(6);
  localparam logic [IO_DW-1:0] SYSCTL_KEEP = lbit(0) | lbit(1) | lbit(2) | lbit(3);
  localparam logic [IO_DW-1:0] IOMAP_KEEP  = lbit(7);

  typedef struct packed {
    logic sreset;
    logic sysctl;
    logic iomap;
    logic equip;
    logic board;
    logic key;
    logic sink;
  } port_sel_t;

endpackage

// File: rtl/sysio_rst_sync.sv
module sysio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysio_port_decode.sv
module sysio_port_decode
  import sysio_pkg::*;
#(
  parameter int unsigned IO_AW = 16
) (
  input  logic [IO_AW-1:0] addr,
  output port_sel_t        sel
);
  localparam int unsigned PAD = (IO_AW > 16) ? IO_AW - 16 : 0;

  function automatic logic hit(input logic [IO_AW-1:0] a, input logic [15:0] p);
    return a == IO_AW'({{PAD{1'b0}}, p});
  endfunction

  logic [N_SINK-1:0] sink_hit;

  for (genvar i = 0; i < N_SINK; i++) begin : g_sink
    assign sink_hit[i] = hit(addr, P_SINKS[i]);
  end

  always_comb begin
    sel        = '0;
    sel.sreset = hit(addr, P_SRESET);
    sel.sysctl = hit(addr, P_SYSCTL);
    sel.iomap  = hit(addr, P_IOMAP);
    sel.equip  = hit(addr, P_EQUIP);
    sel.board  = hit(addr, P_BOARD);
    sel.key    = hit(addr, P_KEY);
    sel.sink   = |sink_hit;
  end
endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
  import sysio_pkg::*;
#(
  parameter logic [IO_DW-1:0] EQUIP_STRAP = '0,
  parameter logic [IO_DW-1:0] BOARD_ID    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  port_sel_t        sel,
  input  logic [IO_DW-1:0] wdata,
  output logic [IO_DW-1:0] rdata,
  output logic             soft_rst,
  output logic             iomap,
  output logic             le_err
);
  logic [IO_DW-1:0] sr_q, sr_d, ctl_q, ctl_d, map_q, map_d;
  logic [IO_DW-1:0] rd_q, rd_d, rd_val;
  logic             err_q, err_d;
  logic             sr_en, ctl_en, map_en;

  always_comb begin
    sr_en  = wr_en & sel.sreset;
    ctl_en = wr_en & sel.sysctl;
    map_en = wr_en & sel.iomap;
    sr_d   = wdata & SRESET_KEEP;
    ctl_d  = wdata & SYSCTL_KEEP;
    map_d  = wdata & IOMAP_KEEP;
    err_d  = sr_en & (|(wdata & LE_REQ));
  end

  always_comb begin
    rd_val = '0;
    if (sel.sreset)              rd_val = sr_q;
    else if (sel.sysctl)         rd_val = ctl_q;
    else if (sel.iomap)          rd_val = map_q;
    else if (sel.equip)          rd_val = EQUIP_STRAP;
    else if (sel.board)          rd_val = BOARD_ID;
    else if (sel.key | sel.sink) rd_val = '0;
    rd_d = rd_en ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ctl_q <= '0;
      map_q <= IOMAP_KEEP;
      err_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (sr_en)  sr_q  <= sr_d;
      if (ctl_en) ctl_q <= ctl_d;
      if (map_en) map_q <= map_d;
      err_q <= err_d;
      rd_q  <= rd_d;
    end
  end

  assign soft_rst = |(sr_q & SRESET_KEEP);
  assign iomap    = |(map_q & IOMAP_KEEP);
  assign le_err   = err_q;
  assign rdata    = rd_q;

  // R2
  sreset_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel.sreset) |=> (soft_rst == $past(wdata[0])));

  // R3
  le_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_err |-> $past(wr_en && sel.sreset && wdata[1]));

  // R4
  sysctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel.sysctl) |=> (ctl_q == ($past(wdata) & 8'hF0)));

  // R5
  iomap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel.iomap) |=> $stable(iomap));

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/sysio_parity_port.sv
module sysio_parity_port #(
  parameter int unsigned          MEM_AW      = 32,
  parameter int unsigned          MEM_DW      = 32,
  parameter logic [MEM_AW-1:0]    PARITY_ADDR = 'hBFFF_EFF0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd,
  input  logic [MEM_AW-1:0]     addr,
  input  logic [MEM_DW/8-1:0]   be,
  output logic                  ack,
  output logic [MEM_DW-1:0]     rdata
);
  logic ack_q, ack_d;

  always_comb begin
    ack_d = rd & (addr == PARITY_ADDR) & (&be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack   = ack_q;
  assign rdata = '0;

  // R11
  parity_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(rd && (be == '1) && (addr == PARITY_ADDR)));
endmodule

// File: rtl/sysio_regblk.sv
module sysio_regblk
  import sysio_pkg::*;
#(
  parameter int unsigned       IO_AW       = 16,
  parameter int unsigned       MEM_AW      = 32,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [7:0]        EQUIP_STRAP = 8'h00,
  parameter logic [7:0]        BOARD_ID    = 8'h00,
  parameter logic [MEM_AW-1:0] PARITY_ADDR = 'hBFFF_EFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [3:0]        mem_be,
  input  logic              mem_rd,
  output logic [31:0]       mem_rdata,
  output logic              mem_ack,
  output logic              soft_rst_o,
  output logic              map_noncontig_o,
  output logic              le_mode_err_o
);
  logic      rst_int_n;
  port_sel_t sel;

  sysio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  sysio_port_decode #(.IO_AW(IO_AW)) u_dec (
    .addr(io_addr), .sel(sel)
  );

  sysio_ctrl_regs #(.EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID(BOARD_ID)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(io_wr), .rd_en(io_rd), .sel(sel),
    .wdata(io_wdata), .rdata(io_rdata), .soft_rst(soft_rst_o),
    .iomap(map_noncontig_o), .le_err(le_mode_err_o)
  );

  sysio_parity_port #(.MEM_AW(MEM_AW), .MEM_DW(32), .PARITY_ADDR(PARITY_ADDR)) u_par (
    .clk(clk), .rst_n(rst_int_n), .rd(mem_rd), .addr(mem_addr), .be(mem_be),
    .ack(mem_ack), .rdata(mem_rdata)
  );

  // R3
  le_err_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (le_mode_err_o && !$past(io_wr)) |=> !le_mode_err_o);
endmodule

// File: tb/tb_sysio_regblk.sv
`timescale 1ns/1ps
module tb_sysio_regblk;
  localparam logic [7:0]  EQ  = 8'hA5;
  localparam logic [7:0]  BID = 8'h3C;
  localparam logic [31:0] PAR = 32'hBFFF_EFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [3:0]  mem_be = '0;
  logic mem_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [31:0] mem_rdata;
  logic mem_ack, soft_rst_o, map_noncontig_o, le_mode_err_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysio_regblk #(.EQUIP_STRAP(EQ), .BOARD_ID(BID)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .soft_rst_o(soft_rst_o), .map_noncontig_o(map_noncontig_o),
    .le_mode_err_o(le_mode_err_o)
  );

  // Behavioural reference state
  int m_sr = 0, m_ctl = 0, m_map = 1, m_err = 0, m_rd = 0, m_ack = 0;
  bit m_rst = 1'b1;
  string m_tag = "R1";

  function automatic int ref_read(input int a);
    case (a)
      'h0092: return m_sr;
      'h081C: return m_ctl;
      'h0850: return m_map;
      'h080C: return EQ;
      'h0852: return BID;
      default: return 0;
    endcase
  endfunction

  function automatic string ref_tag(input int a);
    case (a)
      'h0092: return "R2";
      'h081C: return "R4";
      'h0850: return "R5";
      'h080C, 'h0852: return "R6";
      'h0818: return "R7";
      'h0808, 'h0810, 'h0812, 'h0814: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = 0; m_ctl = 0; m_map = 1; m_err = 0; m_rd = 0; m_ack = 0;
      m_rst = 1'b1; m_tag = "R1";
    end else begin
      int nrd;
      string ntag;
      m_rst = 1'b0;
      nrd = 0;
      ntag = "R10";
      if (io_rd) begin
        nrd = ref_read(int'(io_addr));
        ntag = io_wr ? "R10" : ref_tag(int'(io_addr));
      end
      m_err = (io_wr && io_addr == 16'h0092 && io_wdata[1]) ? 1 : 0;
      if (io_wr) begin
        case (io_addr)
          16'h0092: m_sr  = int'(io_wdata[0]);
          16'h081C: m_ctl = int'(io_wdata) & 'hF0;
          16'h0850: m_map = int'(io_wdata[0]);
          default: ;
        endcase
      end
      m_rd = nrd;
      m_tag = ntag;
      m_ack = (mem_rd && mem_addr == PAR && mem_be == 4'hF) ? 1 : 0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(m_rst ? "R1" : "R2", longint'(soft_rst_o), longint'(m_sr));
      chk(m_rst ? "R1" : "R5", longint'(map_noncontig_o), longint'(m_map));
      chk(m_rst ? "R1" : "R3", longint'(le_mode_err_o), longint'(m_err));
      chk(m_tag, longint'(io_rdata), longint'(m_rd));
      chk(m_rst ? "R1" : "R11", longint'(mem_ack), longint'(m_ack));
      if (mem_ack) chk("R11", longint'(mem_rdata), 0);
    end
  end

  task automatic idle();
    io_wr = 1'b0; io_rd = 1'b0; mem_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0; mem_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    io_addr = a; io_rd = 1'b1; io_wr = 1'b0; mem_rd = 1'b0;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic mrd(input logic [31:0] a, input logic [3:0] be);
    mem_addr = a; mem_be = be; mem_rd = 1'b1; io_wr = 1'b0; io_rd = 1'b0;
    @(negedge clk);
    mem_rd = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] pool [14];
    pool = '{16'h0092, 16'h081C, 16'h0850, 16'h080C, 16'h0852, 16'h0818, 16'h0808,
             16'h0810, 16'h0812, 16'h0814, 16'h0093, 16'h0851, 16'h081D, 16'h0000};
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    // R1 after reset; R2/R3 soft-reset and mode request
    rd(16'h0092); rd(16'h0850); rd(16'h081C); idle();
    wr(16'h0092, 8'hFF); idle(); rd(16'h0092); idle();
    wr(16'h0092, 8'h02); idle(); rd(16'h0092); idle();
    wr(16'h0092, 8'h01); wr(16'h0092, 8'h03); idle();
    // R4 masking
    wr(16'h081C, 8'hFF); rd(16'h081C); wr(16'h081C, 8'h0F); rd(16'h081C); idle();
    // R5 map bit
    wr(16'h0850, 8'h00); rd(16'h0850); wr(16'h0850, 8'hFE); rd(16'h0850);
    wr(16'h0850, 8'h81); rd(16'h0850); idle();
    // R6 straps, R7 key port
    rd(16'h080C); rd(16'h0852); wr(16'h080C, 8'h00); wr(16'h0852, 8'hFF);
    rd(16'h080C); rd(16'h0852); wr(16'h0818, 8'hFF); rd(16'h0818); idle();
    // R8 sinks and R9 undecoded
    wr(16'h081C, 8'hA0);
    foreach (pool[i]) if (i >= 6) wr(pool[i], 8'hFF);
    foreach (pool[i]) rd(pool[i]);
    idle();
    // R10 read and write together
    io_addr = 16'h081C; io_wdata = 8'h50; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    rd(16'h081C); idle();
    // R11 parity port
    mrd(PAR, 4'hF); mrd(PAR, 4'h3); mrd(PAR + 32'd4, 4'hF); mrd(PAR, 4'hF); idle();
    // R1 mid-run reset
    wr(16'h0092, 8'h01); wr(16'h081C, 8'hF0); wr(16'h0850, 8'h00);
    rst_n = 1'b0; idle(); idle();
    rst_n = 1'b1;
    repeat (4) idle();
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      io_addr  = pool[$urandom_range(13, 0)];
      io_wdata = 8'($urandom);
      io_wr    = ($urandom_range(2, 0) == 0);
      io_rd    = ($urandom_range(1, 0) == 0);
      mem_addr = ($urandom_range(1, 0) == 0) ? PAR : PAR ^ (32'd1 << $urandom_range(31, 0));
      mem_be   = ($urandom_range(1, 0) == 0) ? 4'hF : 4'($urandom);
      mem_rd   = ($urandom_range(1, 0) == 0);
      @(negedge clk);
    end
    idle(); idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule